// File: doc/BRIEF.md
# Signed Multiply-Accumulate Coprocessor

This unit sits beside a processor core and keeps a 32-bit accumulator. On each accepted execute beat it can multiply two signed 16-bit arguments and add the product into the accumulator. It can also leave the accumulator alone, so that software can read a result. A 16-bit slice of the accumulator is always visible on the result output. A small mode register picks the operation and which half of the accumulator drives that output. The core loads the mode register through its own write strobe.

A 4-bit flag vector ordered C, V, Z, N (bit 3 down to bit 0) reports signed overflow of the accumulation. The flag is registered. It changes only on an accepted execute beat, so it stays available to the core until the next operation decides its fate. The second multiplicand can come from a 7-bit immediate instead of the second argument.

The execute input is a valid/ready channel. The unit finishes each operation in one cycle, so it never applies back-pressure: `in_ready` stays high outside reset and inside it. A beat is accepted on every rising clock edge where `in_valid` is high. Arguments only need to be stable in that cycle.

Top module: `mac_copro`

## Requirements
- R1: A synchronous reset clears the accumulator, the mode register and the flags to zero, so `res_out` and `flags` both read 0 after reset.
- R2: An accepted beat in MAC mode (mode bits 3:0 = 4'h7) replaces the accumulator with the signed product `arg_a × operand` plus the old accumulator. The addition wraps modulo 2^32, and the wrapped value is stored even when it overflows.
- R3: When `use_imm` is 1 during a MAC beat, the second operand is `imm` sign-extended from 7 to 16 bits, and `arg_b` is ignored.
- R4: Mode bit 4 selects the output half: 1 drives accumulator bits 31:16 onto `res_out`, 0 drives bits 15:0. The output follows the registers combinationally.
- R5: A MAC beat overflows when the product and the old accumulator share a sign bit and the new sum's sign differs from it. Such a beat sets `flags` to 4'b0100 in the following cycle.
- R6: A MAC beat that does not overflow sets `flags` to 4'b0000.
- R7: An accepted beat in result-read mode (mode bits 3:0 = 4'h3) leaves both the accumulator and `flags` unchanged.
- R8: An accepted beat with any other operation code leaves the accumulator unchanged and clears `flags` to 4'b0000.
- R9: Without an accepted beat or a mode write, the accumulator, the mode and the flags hold their values.
- R10: A mode write takes effect in the next cycle. A beat accepted in the same cycle as a mode write runs under the previous mode.
- R11: `in_ready` is always 1, so every beat with `in_valid` high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_wr | input | 1 | Loads `mode_din` into the mode register |
| mode_din | input | 5 | New mode: bit 4 selects the output half, bits 3:0 the operation |
| in_valid | input | 1 | Execute beat offered |
| in_ready | output | 1 | Execute beat accepted (always 1) |
| arg_a | input | 16 | First signed multiplicand |
| arg_b | input | 16 | Second signed multiplicand |
| use_imm | input | 1 | Take the second multiplicand from `imm` |
| imm | input | 7 | Signed 7-bit immediate multiplicand |
| res_out | output | 16 | Selected half of the accumulator |
| flags | output | 4 | C, V, Z, N flags (bit 3 down to bit 0) |

## Verification
The accumulator is observable only through the selected 16-bit half. A corrupted upper or lower word therefore stays hidden until the mode selects that half. The bench flips the half-select often and compares every cycle, so such a corruption shows up within a few beats.

A wrong overflow decision appears on `flags` one cycle after the beat. A wrongly held or cleared V flag only shows on a later read-mode or other-mode beat. For that reason the bench issues those beats directly after overflow cases.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int unsigned MODE_W   = 5;
  localparam int unsigned HALF_BIT = 4;
  localparam int unsigned FLAG_W   = 4;
  localparam logic [3:0] OP_READ   = 4'h3;
  localparam logic [3:0] OP_MAC    = 4'h7;
  localparam logic [FLAG_W-1:0] FLAGS_OVF  = 4'b0100;
  localparam logic [FLAG_W-1:0] FLAGS_NONE = 4'b0000;
endpackage

// File: rtl/mac_mode_reg.sv
module mac_mode_reg #(
  parameter int unsigned MW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [MW-1:0] din,
  output logic [MW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (wr) q <= din;
  end
endmodule

// File: rtl/mac_arith.sv
module mac_arith #(
  parameter int unsigned DW   = 16,
  parameter int unsigned IMMW = 7,
  localparam int unsigned AW  = 2 * DW
) (
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic            use_imm,
  input  logic [IMMW-1:0] imm,
  input  logic [AW-1:0]   acc,
  output logic [AW-1:0]   sum,
  output logic            ovf
);
  logic [DW-1:0] opb;
  logic signed [AW-1:0] prod;

  assign opb  = use_imm ? {{(DW-IMMW){imm[IMMW-1]}}, imm} : b;
  assign prod = $signed(a) * $signed(opb);
  assign sum  = acc + prod;
  // same operand signs, result sign flipped
  assign ovf  = (prod[AW-1] == acc[AW-1]) && (sum[AW-1] != acc[AW-1]);
endmodule

// File: rtl/mac_state.sv
module mac_state
  import mac_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [3:0]        op,
  input  logic [AW-1:0]     sum,
  input  logic              ovf,
  output logic [AW-1:0]     acc_q,
  output logic [FLAG_W-1:0] flags_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      flags_q <= FLAGS_NONE;
    end else if (fire) begin
      unique case (op)
        OP_MAC: begin
          acc_q   <= sum;
          flags_q <= ovf ? FLAGS_OVF : FLAGS_NONE;
        end
        OP_READ: ;
        default: flags_q <= FLAGS_NONE;
      endcase
    end
  end
endmodule

// File: rtl/mac_copro.sv
module mac_copro
  import mac_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned IMMW = 7,
  localparam int unsigned AW  = 2 * DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_din,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     arg_a,
  input  logic [DW-1:0]     arg_b,
  input  logic              use_imm,
  input  logic [IMMW-1:0]   imm,
  output logic [DW-1:0]     res_out,
  output logic [FLAG_W-1:0] flags
);
  logic [MODE_W-1:0] mode_q;
  logic [AW-1:0]     acc_q;
  logic [AW-1:0]     sum;
  logic              ovf;
  logic              fire;

  assign in_ready = 1'b1;
  assign fire     = in_valid & in_ready;

  mac_mode_reg #(.MW(MODE_W)) u_mode (
    .clk(clk), .rst(rst), .wr(mode_wr), .din(mode_din), .q(mode_q)
  );

  mac_arith #(.DW(DW), .IMMW(IMMW)) u_arith (
    .a(arg_a), .b(arg_b), .use_imm(use_imm), .imm(imm),
    .acc(acc_q), .sum(sum), .ovf(ovf)
  );

  mac_state #(.AW(AW)) u_state (
    .clk(clk), .rst(rst), .fire(fire), .op(mode_q[3:0]),
    .sum(sum), .ovf(ovf), .acc_q(acc_q), .flags_q(flags)
  );

  assign res_out = mode_q[HALF_BIT] ? acc_q[AW-1:DW] : acc_q[DW-1:0];
endmodule

// File: rtl/mac_copro_chk.sv
module mac_copro_chk
  import mac_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned IMMW = 7,
  localparam int unsigned AW  = 2 * DW
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_wr,
  input logic              in_valid,
  input logic [DW-1:0]     arg_a,
  input logic [DW-1:0]     arg_b,
  input logic              use_imm,
  input logic [IMMW-1:0]   imm,
  input logic [DW-1:0]     res_out,
  input logic [FLAG_W-1:0] flags,
  input logic [MODE_W-1:0] mode_q,
  input logic [AW-1:0]     acc_q
);
  logic signed [AW-1:0] chk_prod;
  logic [DW-1:0] chk_opb;
  assign chk_opb  = use_imm ? {{(DW-IMMW){imm[IMMW-1]}}, imm} : arg_b;
  assign chk_prod = $signed(arg_a) * $signed(chk_opb);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (flags == '0 && res_out == '0 && acc_q == '0)); // R1
  AST_MAC_SUM: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_q[3:0] == OP_MAC) |=> acc_q == $past(acc_q) + $past(chk_prod)); // R2
  AST_FLAG_CODE: assert property (@(posedge clk) disable iff (rst)
    (flags == FLAGS_NONE || flags == FLAGS_OVF)); // R5
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_q[3:0] == OP_READ) |=> ($stable(acc_q) && $stable(flags))); // R7
  AST_OTHER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode_q[3:0] != OP_READ && mode_q[3:0] != OP_MAC)
      |=> (flags == FLAGS_NONE && $stable(acc_q))); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !mode_wr) |=> ($stable(res_out) && $stable(flags))); // R9
endmodule

bind mac_copro mac_copro_chk #(.DW(DW), .IMMW(IMMW)) u_chk (
  .clk(clk), .rst(rst), .mode_wr(mode_wr), .in_valid(in_valid),
  .arg_a(arg_a), .arg_b(arg_b), .use_imm(use_imm), .imm(imm),
  .res_out(res_out), .flags(flags), .mode_q(mode_q), .acc_q(acc_q)
);

// File: tb/mac_copro_test.sv
module mac_copro_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_wr = 1'b0;
  logic [4:0]  mode_din = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] arg_a = '0, arg_b = '0;
  logic        use_imm = 1'b0;
  logic [6:0]  imm = '0;
  logic [15:0] res_out;
  logic [3:0]  flags;

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] m_acc;
  logic [4:0]  m_mode;
  logic [3:0]  m_flags;

  always #4 clk = ~clk;

  mac_copro uut (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_out();
    return m_mode[4] ? m_acc[31:16] : m_acc[15:0];
  endfunction

  function automatic logic [31:0] product(logic [15:0] a, logic [15:0] b,
                                          bit ui, logic [6:0] im);
    logic signed [15:0] sb;
    logic signed [31:0] p;
    sb = ui ? 16'($signed(im)) : $signed(b);
    p  = 32'($signed(a)) * 32'(sb);
    return p;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #2;
    m_acc = '0; m_mode = '0; m_flags = '0;
    @(negedge clk); rst = 1'b0;
    check("R1", {16'h0, res_out}, 32'h0);
    check("R1", {28'h0, flags}, 32'h0);
  endtask

  task automatic apply(bit mw, logic [4:0] md, bit v, logic [15:0] a,
                       logic [15:0] b, bit ui, logic [6:0] im, string tag);
    logic [31:0] p, s;
    string ot, ft;
    @(negedge clk);
    mode_wr = mw; mode_din = md; in_valid = v;
    arg_a = a; arg_b = b; use_imm = ui; imm = im;
    @(posedge clk);
    ot = "R9"; ft = "R9";
    if (v) begin
      if (m_mode[3:0] == 4'h7) begin
        p = product(a, b, ui, im);
        s = m_acc + p;
        m_flags = (p[31] == m_acc[31] && s[31] != m_acc[31]) ? 4'b0100 : 4'b0000;
        m_acc = s;
        ot = ui ? "R3" : "R2"; ft = m_flags[2] ? "R5" : "R6";
      end else if (m_mode[3:0] == 4'h3) begin
        ot = "R7"; ft = "R7";
      end else begin
        m_flags = 4'b0000; ot = "R8"; ft = "R8";
      end
    end
    if (mw) begin m_mode = md; ot = "R4"; end
    if (tag != "") begin ot = tag; ft = tag; end
    #2;
    mode_wr = 1'b0; in_valid = 1'b0;
    check(ot, {16'h0, res_out}, {16'h0, exp_out()});
    check(ft, {28'h0, flags}, {28'h0, m_flags});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    check("R11", {31'h0, in_ready}, 32'h1);
    // basic MAC, low then high half
    apply(1, 5'h07, 0, 0, 0, 0, 0, "R4");
    apply(0, 0, 1, 16'd3, 16'd4, 0, 0, "R2");
    apply(0, 0, 1, 16'hFFFE, 16'd5, 0, 0, "R2");      // 12 + (-10) = 2
    apply(1, 5'h17, 0, 0, 0, 0, 0, "R4");
    apply(1, 5'h07, 0, 0, 0, 0, 0, "R4");
    // immediate -1 replaces arg_b
    apply(0, 0, 1, 16'd5, 16'd100, 1, 7'h7F, "R3");   // 2 - 5 = -3
    apply(0, 0, 1, 16'd2, 16'd100, 1, 7'h3F, "R3");   // -3 + 126
    // read mode
    apply(1, 5'h13, 0, 0, 0, 0, 0, "R4");
    apply(0, 0, 1, 16'h7FFF, 16'h7FFF, 0, 0, "R7");
    // positive overflow
    do_reset();
    apply(1, 5'h17, 0, 0, 0, 0, 0, "R4");
    apply(0, 0, 1, 16'h8000, 16'h8000, 0, 0, "R6");
    apply(0, 0, 1, 16'h8000, 16'h8000, 0, 0, "R5");   // 0x80000000
    apply(1, 5'h13, 0, 0, 0, 0, 0, "R4");
    apply(0, 0, 1, 16'd9, 16'd9, 0, 0, "R7");         // V held
    apply(1, 5'h17, 0, 0, 0, 0, 0, "R4");
    apply(0, 0, 1, 16'd0, 16'd0, 0, 0, "R6");         // V cleared
    // negative overflow
    apply(0, 0, 1, 16'hFFFF, 16'd1, 0, 0, "R5");      // 0x7FFFFFFF
    apply(1, 5'h05, 0, 0, 0, 0, 0, "R4");
    apply(0, 0, 1, 16'd7, 16'd7, 0, 0, "R8");
    apply(0, 0, 0, 16'd7, 16'd7, 0, 0, "R9");
    // mode write with concurrent beat: old mode applies
    apply(1, 5'h03, 0, 0, 0, 0, 0, "R4");
    apply(1, 5'h07, 1, 16'd4, 16'd4, 0, 0, "R10");
    apply(0, 0, 1, 16'd4, 16'd4, 0, 0, "R10");
    // constrained random
    for (int i = 0; i < 2000; i++) begin
      logic [4:0] md;
      logic [15:0] a, b;
      int sel;
      sel = $urandom_range(0, 4);
      md = (sel == 0) ? 5'h07 : (sel == 1) ? 5'h17 : (sel == 2) ? 5'h13 :
           (sel == 3) ? 5'h03 : 5'($urandom);
      a = ($urandom_range(0, 3) == 0) ? 16'h8000 : 16'($urandom);
      b = ($urandom_range(0, 3) == 0) ? 16'h7FFF : 16'($urandom);
      apply($urandom_range(0, 7) == 0, md, $urandom_range(0, 3) != 0, a, b,
            $urandom_range(0, 5) == 0, 7'($urandom), "");
      if ($urandom_range(0, 499) == 0) do_reset();
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule